// File: doc/BRIEF.md
# Bus Access Watch Comparator

This block watches every memory and I/O cycle that the CPU runs and raises a single halt request on the first cycle that falls inside an armed watch window. A watch has a kind and a range. The kind picks the address space (memory or port) and the direction (read/input, write/output, or either). The range is inclusive. The debug controller arms a watch with an explicit specification, or re-arms the last accepted one with a single command. It can also abort a live watch, which stops the CPU without reporting a hit.

The comparator works on the cycle strobe in the same clock in which the strobe is presented. This keeps the delay between the offending access and the halt as short as possible. After the hit it keeps the address and cycle type of that access for the capture logic to read. The last accepted specification is held in a recall register. That register survives later commands and is cleared only by a monitor exit or by reset.

Top module: `watch_unit`

## Requirements
- R1: A memory watch kind matches cycle types memory read (type 0) and memory write (type 1): kind 0 matches reads only, kind 1 matches writes only, and kind 2 matches either.
- R2: A port watch kind matches input (type 2) and output (type 3) cycles: kind 4 matches inputs only, kind 5 matches outputs only, and kind 6 matches either. Only address bits [7:0] take part in the port comparison.
- R3: A match needs start <= address <= end, both limits included. When the arm command has no end, the range is the single start value.
- R4: `hit_o` asserts combinationally in the cycle the matching strobe is presented. At that clock edge the watch disarms (`armed_o` is 0 from the next cycle, unless a command re-arms it in that cycle). `hit_addr_o` and `hit_type_o` hold the access from the next cycle on.
- R5: An arm whose kind is 5 or 6 and whose port range includes A1h is refused.
- R6: An arm with kind 3 or 7, or with an effective end below its start, is refused. A refused arm pulses `reject_o` for one cycle after the command and leaves the armed state and the recall unchanged.
- R7: `rearm_i` restores the recalled kind and range and sets `armed_o`. With no recalled watch, it pulses `no_prev_o` for one cycle after the command and changes nothing else.
- R8: The recall is kept across hits, aborts, refused arms and re-arms. An accepted arm overwrites it. `exit_i` or reset clears it.
- R9: `abort_i` while armed raises `halt_req_o` in that cycle with `hit_o` low, and disarms the watch. `abort_i` while idle raises nothing.
- R10: When commands come together, exit wins over abort, abort over arm, and arm over rearm. Exit or abort suppresses a hit in the same cycle.
- R11: During and right after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_valid_i | input | 1 | Bus cycle strobe |
| cyc_type_i | input | 2 | 0 mem read, 1 mem write, 2 in, 3 out |
| cyc_addr_i | input | 16 | Cycle address (port number in bits [7:0]) |
| arm_i | input | 1 | Arm with explicit specification |
| arm_kind_i | input | 3 | Watch kind (see R1, R2) |
| arm_start_i | input | 16 | Range start |
| arm_end_i | input | 16 | Range end |
| arm_has_end_i | input | 1 | End given; otherwise single value |
| rearm_i | input | 1 | Re-arm recalled watch |
| abort_i | input | 1 | Abort the active watch |
| exit_i | input | 1 | Monitor exit: disarm, clear recall |
| hit_o | output | 1 | First matching access, same cycle |
| halt_req_o | output | 1 | Halt request (hit or abort) |
| hit_addr_o | output | 16 | Address of the hit access |
| hit_type_o | output | 2 | Cycle type of the hit access |
| armed_o | output | 1 | Watch armed |
| reject_o | output | 1 | Arm refused (one-cycle pulse) |
| no_prev_o | output | 1 | Re-arm with nothing recalled (pulse) |

## Verification
`hit_o` and `halt_req_o` are due in the same cycle as the strobe or abort. `armed_o`, `hit_addr_o`, `hit_type_o`, `reject_o` and `no_prev_o` change one clock after the command or the hit. The bench drives its inputs a short time after each rising edge and compares every output on the falling edge against a behavioural model. That model advances its state only at the rising edge, so combinational results are checked against the old state plus the current inputs, and registered results against the state the model has just built. The directed scenarios add named checks at those same sample points.

// File: rtl/watch_pkg.sv
package watch_pkg;
  typedef enum logic [1:0] {
    CYC_MRD = 2'd0,
    CYC_MWR = 2'd1,
    CYC_IN  = 2'd2,
    CYC_OUT = 2'd3
  } cyc_e;

  // kind[2]: port space, kind[1:0]: 0 read/in, 1 write/out, 2 any, 3 invalid
  localparam logic [1:0] DIR_RD  = 2'd0;
  localparam logic [1:0] DIR_WR  = 2'd1;
  localparam logic [1:0] DIR_ANY = 2'd2;
  localparam logic [1:0] DIR_BAD = 2'd3;
endpackage

// File: rtl/watch_spec_check.sv
module watch_spec_check
  import watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] RSVD_PORT = 8'hA1
) (
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              has_end_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  localparam int unsigned PAD_W = ADDR_W - PORT_W;

  logic [ADDR_W-1:0] end_eff;
  logic              port_space;
  logic              bad_kind;
  logic              bad_order;
  logic              hits_rsvd;
  logic [ADDR_W-1:0] rsvd_ext;

  assign rsvd_ext   = {{PAD_W{1'b0}}, RSVD_PORT};
  assign end_eff    = has_end_i ? end_i : start_i;
  assign port_space = kind_i[2];
  assign bad_kind   = (kind_i[1:0] == DIR_BAD);

  always_comb begin
    if (port_space) begin
      lo_o = {{PAD_W{1'b0}}, start_i[PORT_W-1:0]};
      hi_o = {{PAD_W{1'b0}}, end_eff[PORT_W-1:0]};
    end else begin
      lo_o = start_i;
      hi_o = end_eff;
    end
  end

  assign bad_order = (hi_o < lo_o);
  assign hits_rsvd = port_space && (kind_i[1:0] != DIR_RD)
                     && (lo_o <= rsvd_ext) && (rsvd_ext <= hi_o);
  assign ok_o      = !bad_kind && !bad_order && !hits_rsvd;

  // R6: an accepted range is ordered
  always_comb begin
    if (ok_o) a_r6_ordered: assert (lo_o <= hi_o);
  end
endmodule

// File: rtl/watch_match.sv
module watch_match
  import watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8
) (
  input  logic              valid_i,
  input  logic [1:0]        type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              match_o
);
  localparam int unsigned PAD_W = ADDR_W - PORT_W;

  logic              space_ok;
  logic              dir_ok;
  logic [ADDR_W-1:0] cmp_addr;

  assign space_ok = (type_i[1] == kind_i[2]);
  assign dir_ok   = (kind_i[1:0] == DIR_ANY) ||
                    ((kind_i[1:0] != DIR_BAD) && (kind_i[0] == type_i[0]));
  assign cmp_addr = kind_i[2] ? {{PAD_W{1'b0}}, addr_i[PORT_W-1:0]} : addr_i;
  assign match_o  = valid_i && space_ok && dir_ok
                    && (cmp_addr >= lo_i) && (cmp_addr <= hi_i);
endmodule

// File: rtl/watch_recall.sv
module watch_recall #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              valid_o,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= '0;
      lo_o    <= '0;
      hi_o    <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      kind_o  <= kind_i;
      lo_o    <= lo_i;
      hi_o    <= hi_i;
    end
  end

  a_r8_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
  a_r8_load_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> valid_o);
endmodule

// File: rtl/watch_unit.sv
module watch_unit
  import watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] RSVD_PORT = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_valid_i,
  input  logic [1:0]        cyc_type_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              arm_i,
  input  logic [2:0]        arm_kind_i,
  input  logic [ADDR_W-1:0] arm_start_i,
  input  logic [ADDR_W-1:0] arm_end_i,
  input  logic              arm_has_end_i,
  input  logic              rearm_i,
  input  logic              abort_i,
  input  logic              exit_i,
  output logic              hit_o,
  output logic              halt_req_o,
  output logic [ADDR_W-1:0] hit_addr_o,
  output logic [1:0]        hit_type_o,
  output logic              armed_o,
  output logic              reject_o,
  output logic              no_prev_o
);
  logic              chk_ok;
  logic [ADDR_W-1:0] chk_lo, chk_hi;
  logic              rc_valid;
  logic [2:0]        rc_kind;
  logic [ADDR_W-1:0] rc_lo, rc_hi;
  logic              match;
  logic              armed_q;
  logic              do_abort, do_arm, do_rearm;
  logic              arm_ok, arm_bad, rearm_ok, rearm_none;

  watch_spec_check #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .RSVD_PORT(RSVD_PORT)) u_check (
    .kind_i   (arm_kind_i),
    .start_i  (arm_start_i),
    .end_i    (arm_end_i),
    .has_end_i(arm_has_end_i),
    .ok_o     (chk_ok),
    .lo_o     (chk_lo),
    .hi_o     (chk_hi)
  );

  // the recall doubles as the live specification
  watch_recall #(.ADDR_W(ADDR_W)) u_recall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (exit_i),
    .load_i (arm_ok),
    .kind_i (arm_kind_i),
    .lo_i   (chk_lo),
    .hi_i   (chk_hi),
    .valid_o(rc_valid),
    .kind_o (rc_kind),
    .lo_o   (rc_lo),
    .hi_o   (rc_hi)
  );

  watch_match #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_match (
    .valid_i(cyc_valid_i),
    .type_i (cyc_type_i),
    .addr_i (cyc_addr_i),
    .kind_i (rc_kind),
    .lo_i   (rc_lo),
    .hi_i   (rc_hi),
    .match_o(match)
  );

  // priority: exit > abort > arm > rearm
  assign do_abort   = !exit_i && abort_i;
  assign do_arm     = !exit_i && !abort_i && arm_i;
  assign do_rearm   = !exit_i && !abort_i && !arm_i && rearm_i;
  assign arm_ok     = do_arm && chk_ok;
  assign arm_bad    = do_arm && !chk_ok;
  assign rearm_ok   = do_rearm && rc_valid;
  assign rearm_none = do_rearm && !rc_valid;

  assign hit_o      = armed_q && match && !exit_i && !abort_i;
  assign halt_req_o = hit_o || (do_abort && armed_q);
  assign armed_o    = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      hit_addr_o <= '0;
      hit_type_o <= '0;
      reject_o   <= 1'b0;
      no_prev_o  <= 1'b0;
    end else begin
      reject_o  <= arm_bad;
      no_prev_o <= rearm_none;
      if (exit_i || do_abort)      armed_q <= 1'b0;
      else if (arm_ok || rearm_ok) armed_q <= 1'b1;
      else if (hit_o)              armed_q <= 1'b0;
      if (hit_o) begin
        hit_addr_o <= cyc_addr_i;
        hit_type_o <= cyc_type_i;
      end
    end
  end

  a_r4_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !arm_i && !rearm_i) |=> !armed_o);
  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (hit_addr_o == $past(cyc_addr_i)) && (hit_type_o == $past(cyc_type_i)));
  a_r5_reserved_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_type_i == CYC_OUT && cyc_addr_i[PORT_W-1:0] == RSVD_PORT) |-> !hit_o);
  a_r7_no_prev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_i && !arm_i && !abort_i && !exit_i && !rc_valid) |=> no_prev_o && !armed_o);
  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !exit_i && armed_o) |-> halt_req_o && !hit_o);
  a_r9_abort_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !armed_o);
  a_r6_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_bad && !hit_o) |=> $stable(armed_o) && reject_o);
endmodule

// File: tb/tb_watch_unit.sv
`timescale 1ns/1ps
module tb_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [1:0]  cyc_type = 2'd0;
  logic [15:0] cyc_addr = 16'd0;
  logic        arm = 1'b0;
  logic [2:0]  arm_kind = 3'd0;
  logic [15:0] arm_start = 16'd0;
  logic [15:0] arm_end = 16'd0;
  logic        arm_has_end = 1'b0;
  logic        rearm = 1'b0;
  logic        abort_c = 1'b0;
  logic        exit_c = 1'b0;
  logic        hit, halt_req, armed, reject, no_prev;
  logic [15:0] hit_addr;
  logic [1:0]  hit_type;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #5 clk = ~clk;

  watch_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cyc_valid_i(cyc_valid), .cyc_type_i(cyc_type), .cyc_addr_i(cyc_addr),
    .arm_i(arm), .arm_kind_i(arm_kind), .arm_start_i(arm_start),
    .arm_end_i(arm_end), .arm_has_end_i(arm_has_end),
    .rearm_i(rearm), .abort_i(abort_c), .exit_i(exit_c),
    .hit_o(hit), .halt_req_o(halt_req), .hit_addr_o(hit_addr),
    .hit_type_o(hit_type), .armed_o(armed), .reject_o(reject), .no_prev_o(no_prev)
  );

  // behavioural reference model
  bit m_armed, m_valid, m_rej, m_np;
  int m_kind, m_lo, m_hi, m_haddr, m_htype;

  function automatic bit spec_ok(int k, int s, int e);
    if (k == 3 || k == 7) return 0;
    if (k >= 4) begin s = s % 256; e = e % 256; end
    if (e < s) return 0;
    if ((k == 5 || k == 6) && s <= 161 && e >= 161) return 0;
    return 1;
  endfunction

  function automatic bit covers(int k, int lo, int hi, int t, int a);
    bit is_port = (k >= 4);
    int d = k % 4;
    if (is_port != (t >= 2)) return 0;
    if (d != 2 && d != t % 2) return 0;
    if (is_port) a = a % 256;
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic bit exp_hit();
    return m_armed && m_valid && cyc_valid && !exit_c && !abort_c &&
           covers(m_kind, m_lo, m_hi, int'(cyc_type), int'(cyc_addr));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_valid = 0; m_rej = 0; m_np = 0;
      m_kind = 0; m_lo = 0; m_hi = 0; m_haddr = 0; m_htype = 0;
    end else begin
      bit h;
      int s, e;
      h = exp_hit();
      m_rej = 0; m_np = 0;
      if (h) begin m_haddr = int'(cyc_addr); m_htype = int'(cyc_type); m_armed = 0; end
      if (exit_c) begin m_armed = 0; m_valid = 0; end
      else if (abort_c) m_armed = 0;
      else if (arm) begin
        s = int'(arm_start);
        e = arm_has_end ? int'(arm_end) : s;
        if (spec_ok(int'(arm_kind), s, e)) begin
          if (arm_kind >= 4) begin s = s % 256; e = e % 256; end
          m_kind = int'(arm_kind); m_lo = s; m_hi = e; m_valid = 1; m_armed = 1;
        end else m_rej = 1;
      end else if (rearm) begin
        if (m_valid) m_armed = 1; else m_np = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 hit_o", hit, exp_hit());
      chk("R9 halt_req_o", halt_req, exp_hit() || (m_armed && abort_c && !exit_c));
      chk("R4 armed_o", armed, m_armed);
      chk("R4 hit_addr_o", hit_addr, m_haddr);
      chk("R4 hit_type_o", hit_type, m_htype);
      chk("R6 reject_o", reject, m_rej);
      chk("R7 no_prev_o", no_prev, m_np);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    cyc_valid = 0; arm = 0; rearm = 0; abort_c = 0; exit_c = 0; arm_has_end = 0;
  endtask
  task automatic bus(input logic [1:0] t, input logic [15:0] a);
    tick(); cyc_valid = 1; cyc_type = t; cyc_addr = a;
  endtask
  task automatic arm_cmd(input logic [2:0] k, input logic [15:0] s,
                         input logic [15:0] e, input logic he);
    tick(); arm = 1; arm_kind = k; arm_start = s; arm_end = e; arm_has_end = he;
  endtask
  task automatic sample();
    @(negedge clk);
  endtask

  initial begin
    #1;
    // R11 reset state
    chk("R11 hit_o in reset", hit, 0);
    chk("R11 armed_o in reset", armed, 0);
    chk("R11 halt_req_o in reset", halt_req, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    sample();
    chk("R11 armed after reset", armed, 0);
    chk("R11 hit_addr after reset", hit_addr, 0);

    // R7 rearm with nothing recalled
    tick(); rearm = 1;
    tick(); sample();
    chk("R7 no_prev pulse", no_prev, 1);
    chk("R7 still idle", armed, 0);

    // R1 R3 memory read window
    arm_cmd(3'd0, 16'h1000, 16'h10FF, 1);
    bus(2'd1, 16'h1000); sample();
    chk("R1 write ignored by read watch", hit, 0);
    bus(2'd0, 16'h0FFF); sample();
    chk("R3 below start no hit", hit, 0);
    bus(2'd0, 16'h1100); sample();
    chk("R3 above end no hit", hit, 0);
    bus(2'd0, 16'h10FF); sample();
    chk("R1 R3 read at end hits", hit, 1);
    chk("R4 halt with hit", halt_req, 1);
    tick(); sample();
    chk("R4 disarmed after hit", armed, 0);
    chk("R4 captured addr", hit_addr, 16'h10FF);
    bus(2'd0, 16'h1010); sample();
    chk("R4 one-shot no second hit", hit, 0);

    // R8 recall survives other ops, R7 rearm
    arm_cmd(3'd3, 16'h0, 16'h0, 0);
    tick(); rearm = 1;
    tick(); sample();
    chk("R7 rearm sets armed", armed, 1);
    bus(2'd0, 16'h1000); sample();
    chk("R8 recalled range hits at start", hit, 1);

    // R3 single address, R1 write kind
    arm_cmd(3'd1, 16'h2000, 16'hFFFF, 0);
    bus(2'd1, 16'h2001); sample();
    chk("R3 single value excludes next", hit, 0);
    bus(2'd0, 16'h2000); sample();
    chk("R1 read ignored by write watch", hit, 0);
    bus(2'd1, 16'h2000); sample();
    chk("R1 write single hits", hit, 1);
    tick(); sample();
    chk("R4 captured type write", hit_type, 1);

    // R1 any direction
    arm_cmd(3'd2, 16'h3000, 16'h3003, 1);
    bus(2'd2, 16'h3001); sample();
    chk("R1 port cycle ignored by mem watch", hit, 0);
    bus(2'd0, 16'h3002); sample();
    chk("R1 any-direction read hits", hit, 1);

    // R2 port input, low byte only
    arm_cmd(3'd4, 16'h0010, 16'h0020, 1);
    bus(2'd3, 16'h0015); sample();
    chk("R2 out ignored by input watch", hit, 0);
    bus(2'd0, 16'h0015); sample();
    chk("R2 mem ignored by port watch", hit, 0);
    bus(2'd2, 16'hAB15); sample();
    chk("R2 input high bits ignored hits", hit, 1);

    // R5 reserved port
    arm_cmd(3'd5, 16'h00A0, 16'h00A2, 1);
    tick(); sample();
    chk("R5 out range over A1 refused", reject, 1);
    chk("R6 refused keeps idle", armed, 0);
    arm_cmd(3'd6, 16'h00A1, 16'h0, 0);
    tick(); sample();
    chk("R5 any on A1 refused", reject, 1);
    arm_cmd(3'd5, 16'h00A2, 16'h00A8, 1);
    tick(); sample();
    chk("R5 out range clear of A1 accepted", armed, 1);
    bus(2'd3, 16'h00A5); sample();
    chk("R2 output hits", hit, 1);
    arm_cmd(3'd4, 16'h00A1, 16'h0, 0);
    tick(); sample();
    chk("R5 input on A1 accepted", armed, 1);
    bus(2'd3, 16'h00A1); sample();
    chk("R5 out A1 no hit", hit, 0);

    // R6 bad order and invalid kind, state kept
    arm_cmd(3'd0, 16'h5000, 16'h4FFF, 1);
    tick(); sample();
    chk("R6 end below start refused", reject, 1);
    chk("R6 armed kept", armed, 1);
    arm_cmd(3'd7, 16'h0, 16'h0, 0);
    tick(); sample();
    chk("R6 invalid kind refused", reject, 1);
    bus(2'd2, 16'h00A1); sample();
    chk("R8 recall unchanged by refusals", hit, 1);

    // R9 abort
    tick(); rearm = 1;
    tick(); abort_c = 1; sample();
    chk("R9 abort halts", halt_req, 1);
    chk("R9 abort no hit", hit, 0);
    tick(); sample();
    chk("R9 abort disarms", armed, 0);
    tick(); abort_c = 1; sample();
    chk("R9 abort idle no halt", halt_req, 0);

    // R10 priority
    tick(); rearm = 1;
    tick(); abort_c = 1; cyc_valid = 1; cyc_type = 2'd2; cyc_addr = 16'h00A1; sample();
    chk("R10 abort suppresses hit", hit, 0);
    arm_cmd(3'd0, 16'h0, 16'h10, 1); abort_c = 1;
    tick(); sample();
    chk("R10 abort beats arm", armed, 0);
    arm_cmd(3'd0, 16'h0, 16'h10, 1); rearm = 1;
    tick(); sample();
    chk("R10 arm beats rearm", armed, 1);
    bus(2'd0, 16'h0008); sample();
    chk("R8 new arm overwrote recall", hit, 1);

    // R8 exit clears recall
    tick(); exit_c = 1; rearm = 1;
    tick(); sample();
    chk("R10 exit beats rearm", armed, 0);
    tick(); rearm = 1;
    tick(); sample();
    chk("R8 exit cleared recall", no_prev, 1);
    repeat (3) tick();
    sample();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule